// File: doc/BRIEF.md
# Video I/O Port Router

This block sits on the byte-wide host I/O path and decodes every access in the 0x3B0 to 0x3DF window. Each access is steered to one of three targets: an emulated monochrome adapter, an emulated color adapter, or a VGA core. Two emulation-enable bits from the host mode register pick the adapters. A mono/color select bit is captured from writes to the VGA miscellaneous output port at 0x3C2. For accesses that reach an emulated adapter, the block computes the adapter's register address. For the CRTC data ports, that address is formed from the index value that was last written to the matching index port.

The router also produces one-cycle interrupt request pulses when the host writes to an adapter window whose emulation is enabled. It answers status-port reads itself: while emulation is on, it synthesizes a retrace status byte from the current vertical line count and the number of cycles since the previous status read. All routing is combinational from the port, the direction, the enable bits and the latched select. Only the select bit, the two CRTC index copies, the interrupt pulses and the retrace cycle counter are registered.

Top module: `vid_io_router`

## Requirements
- R1: With vga_present_i high, ports 0x3C0 to 0x3CF and port 0x3B9 route to VGA (route_o = 3) whatever the enable bits are. With vga_present_i low, the same ports are ignored (route_o = 0).
- R2: A write to 0x3C2 captures wdata bit 0 as the select (0 = mono, 1 = color). The new value governs accesses from the next cycle on. No other access changes the select.
- R3: With mda_emu_en_i high, the mono ports route to the mono adapter (route_o = 1). The target addresses are: even ports 0x3B0 to 0x3B6 go to index address 0x1FF, and a write there captures the low 4 data bits as the mono index. Port 0x3B8 goes to 0x2FF. Ports 0x3BB to 0x3BF, and writes to 0x3BA, go to 0x01F.
- R4: With mda_emu_en_i high, odd ports 0x3B1 to 0x3B7 go to address 0x2A1 + 2 x (captured mono index). The index used is the value captured before the current cycle.
- R5: With cga_emu_en_i high, the color ports route to the color adapter (route_o = 2). The target addresses are: even 0x3D0 to 0x3D6 go to 0x21F and capture the color index. Odd 0x3D1 to 0x3D7 go to 0x2C1 + 2 x index. 0x3D8 goes to 0x23F, 0x3D9 to 0x25F and 0x3DD to 0x29F. 0x3DE, 0x3DF and writes to 0x3DA go to 0x01F.
- R6: When an adapter's emulation is off, its CRTC ports (0x3x0 to 0x3x7) and status port (0x3xA) route to VGA only if VGA is present and the select matches: 0 for 0x3Bx, 1 for 0x3Dx. Every other port of that adapter is ignored.
- R7: An ignored access, an idle cycle or a port outside the window gives route_o = 0, tgt_addr_o = 0 and rdata_o = 0xFF. Ports 0x3DB and 0x3DC are always ignored.
- R8: A write to 0x3B0 to 0x3BE while mda_emu_en_i is high makes irq_mono_o high for exactly the next cycle. Any other cycle leaves it low.
- R9: A write to 0x3D0 to 0x3DE while cga_emu_en_i is high makes irq_color_o high for exactly the next cycle. Any other cycle leaves it low.
- R10: A read of 0x3BA with mono emulation on, or of 0x3DA with color emulation on, is served locally (route_o = 4). While line_i is below RETRACE_LINES, rdata_o has bits 3 and 0 set.
- R11: In a local status read, bit 0 is also set when the shared cycle counter exceeds LINE_CYCLES/2. The counter clears at each local status read and counts cycles after it. Bits 7:4 and 2:1 are always zero.
- R12: After reset the select is 0, both captured indices are 0, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Host I/O access present this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_port_i | input | PORT_W | I/O port number |
| acc_wdata_i | input | 8 | Write data byte |
| mda_emu_en_i | input | 1 | Mono adapter emulation enable (mode register bit 3) |
| cga_emu_en_i | input | 1 | Color adapter emulation enable (mode register bit 4) |
| vga_present_i | input | 1 | VGA core fitted |
| line_i | input | LINE_W | Current vertical line count |
| route_o | output | 3 | 0 none, 1 mono adapter, 2 color adapter, 3 VGA, 4 local status |
| tgt_addr_o | output | 10 | Adapter register address for routes 1 and 2, else 0 |
| rdata_o | output | 8 | Local status byte for route 4, else 0xFF |
| irq_mono_o | output | 1 | Mono write interrupt request pulse |
| irq_color_o | output | 1 | Color write interrupt request pulse |

## Verification
A write to a CRTC index port does two things that land in the same following cycle: it captures the index, and it raises an interrupt pulse. The bench therefore places a data-port access right after each index write. In that cycle it judges, together, the data address built from the new index and the interrupt pulse caused by the previous write. Select changes are provoked the same way: a write to 0x3C2 is followed at once by a CRTC access, which must follow the new select. Status reads are spaced on both sides of the half-line count.

// File: rtl/vid_io_pkg.sv
package vid_io_pkg;
  localparam int ADDR_W = 10;

  typedef enum logic [2:0] {
    RT_NONE  = 3'd0,
    RT_MONO  = 3'd1,
    RT_COLOR = 3'd2,
    RT_VGA   = 3'd3,
    RT_LOCAL = 3'd4
  } route_e;

  localparam logic [ADDR_W-1:0] MONO_IDX_A  = 10'h1FF;
  localparam logic [ADDR_W-1:0] MONO_DAT_A  = 10'h2A1;
  localparam logic [ADDR_W-1:0] MONO_MODE_A = 10'h2FF;
  localparam logic [ADDR_W-1:0] COL_IDX_A   = 10'h21F;
  localparam logic [ADDR_W-1:0] COL_DAT_A   = 10'h2C1;
  localparam logic [ADDR_W-1:0] COL_MODE_A  = 10'h23F;
  localparam logic [ADDR_W-1:0] COL_PAL_A   = 10'h25F;
  localparam logic [ADDR_W-1:0] COL_EXT_A   = 10'h29F;
  localparam logic [ADDR_W-1:0] DUMMY_A     = 10'h01F;

  localparam logic [11:0] PG_MONO  = 12'h03B;
  localparam logic [11:0] PG_VGA   = 12'h03C;
  localparam logic [11:0] PG_COLOR = 12'h03D;
endpackage

// File: rtl/vio_decode.sv
module vio_decode
  import vid_io_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              mda_en_i,
  input  logic              cga_en_i,
  input  logic              vga_present_i,
  input  logic              sel_color_i,
  input  logic [IDX_W-1:0]  mono_idx_i,
  input  logic [IDX_W-1:0]  color_idx_i,
  output route_e            route_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mono_idx_we_o,
  output logic              color_idx_we_o,
  output logic              sel_we_o,
  output logic              status_rd_o,
  output logic              irq_mono_req_o,
  output logic              irq_color_req_o
);
  localparam int PG_W = PORT_W - 4;

  logic [3:0] lo;
  logic       pg_mono, pg_color, pg_vga;
  logic       crtc_or_stat;
  logic [ADDR_W-1:0] mono_off, color_off;

  assign lo       = port_i[3:0];
  assign pg_mono  = (port_i[PORT_W-1:4] == PG_W'(PG_MONO));
  assign pg_color = (port_i[PORT_W-1:4] == PG_W'(PG_COLOR));
  assign pg_vga   = (port_i[PORT_W-1:4] == PG_W'(PG_VGA));
  assign crtc_or_stat = !lo[3] || (lo == 4'hA);
  assign mono_off  = ADDR_W'({mono_idx_i, 1'b0});
  assign color_off = ADDR_W'({color_idx_i, 1'b0});

  // range-based request, independent of the chosen route
  assign irq_mono_req_o  = valid_i && write_i && pg_mono  && (lo != 4'hF) && mda_en_i;
  assign irq_color_req_o = valid_i && write_i && pg_color && (lo != 4'hF) && cga_en_i;

  always_comb begin
    route_o        = RT_NONE;
    addr_o         = '0;
    mono_idx_we_o  = 1'b0;
    color_idx_we_o = 1'b0;
    sel_we_o       = 1'b0;
    status_rd_o    = 1'b0;
    if (valid_i) begin
      if (pg_vga || (pg_mono && lo == 4'h9)) begin
        if (vga_present_i) route_o = RT_VGA;
        sel_we_o = write_i && pg_vga && (lo == 4'h2);
      end else if (pg_mono) begin
        if (mda_en_i) begin
          route_o = RT_MONO;
          if (!lo[3]) begin
            if (!lo[0]) begin
              addr_o        = MONO_IDX_A;
              mono_idx_we_o = write_i;
            end else begin
              addr_o = MONO_DAT_A + mono_off;
            end
          end else if (lo == 4'h8) begin
            addr_o = MONO_MODE_A;
          end else if (lo == 4'hA && !write_i) begin
            route_o     = RT_LOCAL;
            status_rd_o = 1'b1;
          end else begin
            addr_o = DUMMY_A;
          end
        end else if (crtc_or_stat && vga_present_i && !sel_color_i) begin
          route_o = RT_VGA;
        end
      end else if (pg_color) begin
        if (cga_en_i) begin
          route_o = RT_COLOR;
          if (!lo[3]) begin
            if (!lo[0]) begin
              addr_o         = COL_IDX_A;
              color_idx_we_o = write_i;
            end else begin
              addr_o = COL_DAT_A + color_off;
            end
          end else begin
            case (lo)
              4'h8: addr_o = COL_MODE_A;
              4'h9: addr_o = COL_PAL_A;
              4'hA: begin
                if (write_i) addr_o = DUMMY_A;
                else begin
                  route_o     = RT_LOCAL;
                  status_rd_o = 1'b1;
                end
              end
              4'hD: addr_o = COL_EXT_A;
              4'hE, 4'hF: addr_o = DUMMY_A;
              default: route_o = RT_NONE;
            endcase
          end
        end else if (crtc_or_stat && vga_present_i && sel_color_i) begin
          route_o = RT_VGA;
        end
      end
    end
  end
endmodule

// File: rtl/vio_index_reg.sv
module vio_index_reg #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] d_i,
  output logic [IDX_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/vio_retrace.sv
module vio_retrace #(
  parameter int LINE_W        = 10,
  parameter int LINE_CYCLES   = 64,
  parameter int RETRACE_LINES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [7:0]        stat_o
);
  localparam int HALF  = LINE_CYCLES / 2;
  localparam int CNT_W = $clog2(LINE_CYCLES) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             in_vb, late;

  // saturates just past the threshold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (rd_i)                    cnt_q <= '0;
    else if (cnt_q <= CNT_W'(HALF))   cnt_q <= cnt_q + 1'b1;
  end

  assign in_vb  = (line_i < LINE_W'(RETRACE_LINES));
  assign late   = (cnt_q > CNT_W'(HALF));
  assign stat_o = {4'b0000, in_vb, 2'b00, in_vb | late};
endmodule

// File: rtl/vio_irq.sv
module vio_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mono_req_i,
  input  logic color_req_i,
  output logic irq_mono_o,
  output logic irq_color_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_mono_o  <= 1'b0;
      irq_color_o <= 1'b0;
    end else begin
      irq_mono_o  <= mono_req_i;
      irq_color_o <= color_req_i;
    end
  end
endmodule

// File: rtl/vid_io_router.sv
module vid_io_router
  import vid_io_pkg::*;
#(
  parameter int PORT_W        = 16,
  parameter int LINE_W        = 10,
  parameter int LINE_CYCLES   = 64,
  parameter int RETRACE_LINES = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [PORT_W-1:0] acc_port_i,
  input  logic [7:0]        acc_wdata_i,
  input  logic              mda_emu_en_i,
  input  logic              cga_emu_en_i,
  input  logic              vga_present_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [2:0]        route_o,
  output logic [9:0]        tgt_addr_o,
  output logic [7:0]        rdata_o,
  output logic              irq_mono_o,
  output logic              irq_color_o
);
  localparam int IDX_W = 4;
  localparam int N_ADP = 2;

  route_e                        route;
  logic [ADDR_W-1:0]             addr;
  logic [N_ADP-1:0]              idx_we;
  logic [N_ADP-1:0][IDX_W-1:0]   idx_q;
  logic                          sel_we, sel_q, stat_rd;
  logic                          irq_m_req, irq_c_req;
  logic [7:0]                    stat;
  logic                          unused_wdata;

  assign unused_wdata = ^acc_wdata_i[7:IDX_W];

  vio_decode #(.PORT_W(PORT_W), .IDX_W(IDX_W)) dec_i (
    .valid_i        (acc_valid_i),
    .write_i        (acc_write_i),
    .port_i         (acc_port_i),
    .mda_en_i       (mda_emu_en_i),
    .cga_en_i       (cga_emu_en_i),
    .vga_present_i  (vga_present_i),
    .sel_color_i    (sel_q),
    .mono_idx_i     (idx_q[0]),
    .color_idx_i    (idx_q[1]),
    .route_o        (route),
    .addr_o         (addr),
    .mono_idx_we_o  (idx_we[0]),
    .color_idx_we_o (idx_we[1]),
    .sel_we_o       (sel_we),
    .status_rd_o    (stat_rd),
    .irq_mono_req_o (irq_m_req),
    .irq_color_req_o(irq_c_req)
  );

  // index 0 = mono adapter, index 1 = color adapter
  for (genvar a = 0; a < N_ADP; a++) begin : g_idx
    vio_index_reg #(.IDX_W(IDX_W)) idx_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (idx_we[a]),
      .d_i   (acc_wdata_i[IDX_W-1:0]),
      .q_o   (idx_q[a])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= 1'b0;
    else if (sel_we) sel_q <= acc_wdata_i[0];
  end

  vio_retrace #(
    .LINE_W(LINE_W), .LINE_CYCLES(LINE_CYCLES), .RETRACE_LINES(RETRACE_LINES)
  ) rtr_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rd_i  (stat_rd),
    .line_i(line_i),
    .stat_o(stat)
  );

  vio_irq irq_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mono_req_i (irq_m_req),
    .color_req_i(irq_c_req),
    .irq_mono_o (irq_mono_o),
    .irq_color_o(irq_color_o)
  );

  assign route_o    = route;
  assign tgt_addr_o = addr;
  assign rdata_o    = (route == RT_LOCAL) ? stat : 8'hFF;
endmodule

// File: rtl/vid_io_router_chk.sv
module vid_io_router_chk #(
  parameter int PORT_W        = 16,
  parameter int LINE_W        = 10,
  parameter int RETRACE_LINES = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_write_i,
  input logic [PORT_W-1:0] acc_port_i,
  input logic              mda_emu_en_i,
  input logic              cga_emu_en_i,
  input logic [LINE_W-1:0] line_i,
  input logic [2:0]        route_o,
  input logic [9:0]        tgt_addr_o,
  input logic [7:0]        rdata_o,
  input logic              irq_mono_o,
  input logic              irq_color_o,
  input logic              sel_q
);
  logic mono_wr, color_wr, sel_wr;
  assign mono_wr  = acc_valid_i && acc_write_i && mda_emu_en_i &&
                    acc_port_i >= PORT_W'(16'h3B0) && acc_port_i <= PORT_W'(16'h3BE);
  assign color_wr = acc_valid_i && acc_write_i && cga_emu_en_i &&
                    acc_port_i >= PORT_W'(16'h3D0) && acc_port_i <= PORT_W'(16'h3DE);
  assign sel_wr   = acc_valid_i && acc_write_i && acc_port_i == PORT_W'(16'h3C2);

  // R8
  mono_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mono_wr |=> irq_mono_o);
  // R8
  mono_irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mono_wr |=> !irq_mono_o);
  // R9
  color_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    color_wr |=> irq_color_o);
  // R9
  color_irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !color_wr |=> !irq_color_o);
  // R2
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_wr |=> $stable(sel_q));
  // R7
  ignore_ff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_o == 3'd0 |-> (rdata_o == 8'hFF && tgt_addr_o == 10'd0));
  // R10
  vblank_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o == 3'd4 && line_i < LINE_W'(RETRACE_LINES)) |-> (rdata_o[3] && rdata_o[0]));
  // R11
  stat_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route_o == 3'd4 |-> (rdata_o[7:4] == 4'd0 && rdata_o[2:1] == 2'd0));
  // R4
  dat_odd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_o == 3'd1 && !acc_port_i[3] && acc_port_i[0]) |-> tgt_addr_o[0]);
endmodule

bind vid_io_router vid_io_router_chk #(
  .PORT_W(PORT_W), .LINE_W(LINE_W), .RETRACE_LINES(RETRACE_LINES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_port_i  (acc_port_i),
  .mda_emu_en_i(mda_emu_en_i),
  .cga_emu_en_i(cga_emu_en_i),
  .line_i      (line_i),
  .route_o     (route_o),
  .tgt_addr_o  (tgt_addr_o),
  .rdata_o     (rdata_o),
  .irq_mono_o  (irq_mono_o),
  .irq_color_o (irq_color_o),
  .sel_q       (sel_q)
);

// File: tb/vid_io_router_tb_top.sv
module vid_io_router_tb_top;
  localparam logic [2:0] NONE = 3'd0, MONO = 3'd1, COLR = 3'd2, VGA = 3'd3, LOCL = 3'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0;
  logic [15:0] port = '0;
  logic [7:0]  wdata = '0;
  logic        mda = 1'b0, cga = 1'b0, vp = 1'b0;
  logic [9:0]  line = '0;
  logic [2:0]  route;
  logic [9:0]  taddr;
  logic [7:0]  rdata;
  logic        irq_m, irq_c;

  always #10 clk = ~clk;

  vid_io_router dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_port_i(port), .acc_wdata_i(wdata), .mda_emu_en_i(mda),
    .cga_emu_en_i(cga), .vga_present_i(vp), .line_i(line),
    .route_o(route), .tgt_addr_o(taddr), .rdata_o(rdata),
    .irq_mono_o(irq_m), .irq_color_o(irq_c)
  );

  typedef struct {
    logic [2:0] r;
    logic [9:0] a;
    logic [7:0] d;
    logic       im;
    logic       ic;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0;
  logic nxt_m = 1'b0, nxt_c = 1'b0;
  bit   done = 1'b0;

  task automatic push(input logic [2:0] r, input logic [9:0] a, input logic [7:0] d,
                      input string req);
    exp_t e;
    e.r = r; e.a = a; e.d = d; e.im = nxt_m; e.ic = nxt_c; e.req = req;
    q.push_back(e);
    nxt_m = valid && wr && mda && port >= 16'h3B0 && port <= 16'h3BE;
    nxt_c = valid && wr && cga && port >= 16'h3D0 && port <= 16'h3DE;
  endtask

  task automatic cfg(input logic m, input logic c, input logic v, input logic [9:0] ln,
                     input string req);
    @(negedge clk);
    valid = 1'b0; wr = 1'b0; mda = m; cga = c; vp = v; line = ln;
    push(NONE, 10'd0, 8'hFF, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0; wr = 1'b0;
      push(NONE, 10'd0, 8'hFF, "R7");
    end
  endtask

  task automatic rd(input logic [15:0] p, input logic [2:0] r, input logic [9:0] a,
                    input string req);
    @(negedge clk);
    valid = 1'b1; wr = 1'b0; port = p;
    push(r, a, 8'hFF, req);
  endtask

  task automatic wrt(input logic [15:0] p, input logic [7:0] d, input logic [2:0] r,
                     input logic [9:0] a, input string req);
    @(negedge clk);
    valid = 1'b1; wr = 1'b1; port = p; wdata = d;
    push(r, a, 8'hFF, req);
  endtask

  task automatic st(input logic [15:0] p, input logic [7:0] d, input string req);
    @(negedge clk);
    valid = 1'b1; wr = 1'b0; port = p;
    push(LOCL, 10'd0, d, req);
  endtask

  // monitor: samples a quarter period before the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (route !== e.r || taddr !== e.a || rdata !== e.d || irq_m !== e.im || irq_c !== e.ic) begin
          n_fail++;
          $display("FAIL %s: got route=%0d addr=%h rdata=%h irq=%b%b exp route=%0d addr=%h rdata=%h irq=%b%b",
                   e.req, route, taddr, rdata, irq_m, irq_c, e.r, e.a, e.d, e.im, e.ic);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    cfg(1'b0, 1'b0, 1'b1, 10'd100, "R12");
    rd(16'h3B4, VGA, 10'd0, "R12");
    rd(16'h3D4, NONE, 10'd0, "R6");
    rd(16'h3C5, VGA, 10'd0, "R1");
    rd(16'h3B9, VGA, 10'd0, "R1");
    // R2 select to color, used in the very next cycle
    wrt(16'h3C2, 8'h01, VGA, 10'd0, "R2");
    rd(16'h3D4, VGA, 10'd0, "R2");
    rd(16'h3B4, NONE, 10'd0, "R6");
    rd(16'h3DA, VGA, 10'd0, "R6");
    rd(16'h3D8, NONE, 10'd0, "R6");
    wrt(16'h3C2, 8'hFE, VGA, 10'd0, "R2");
    rd(16'h3BA, VGA, 10'd0, "R2");
    rd(16'h3C7, VGA, 10'd0, "R2");
    // R1 no VGA
    cfg(1'b0, 1'b0, 1'b0, 10'd100, "R7");
    rd(16'h3C5, NONE, 10'd0, "R1");
    rd(16'h3B4, NONE, 10'd0, "R6");
    rd(16'h3A0, NONE, 10'd0, "R7");
    // mono emulation
    cfg(1'b1, 1'b0, 1'b1, 10'd100, "R7");
    rd(16'h3B5, MONO, 10'h2A1, "R12");
    wrt(16'h3B4, 8'h1B, MONO, 10'h1FF, "R3");
    rd(16'h3B5, MONO, 10'h2B7, "R4");
    wrt(16'h3B7, 8'h55, MONO, 10'h2B7, "R4");
    rd(16'h3B8, MONO, 10'h2FF, "R3");
    wrt(16'h3BC, 8'h00, MONO, 10'h01F, "R3");
    wrt(16'h3BF, 8'h00, MONO, 10'h01F, "R3");
    rd(16'h3B8, MONO, 10'h2FF, "R8");
    wrt(16'h3B9, 8'h00, VGA, 10'd0, "R1");
    rd(16'h3B1, MONO, 10'h2B7, "R8");
    wrt(16'h3BA, 8'h00, MONO, 10'h01F, "R3");
    wrt(16'h3B0, 8'h02, MONO, 10'h1FF, "R3");
    rd(16'h3B3, MONO, 10'h2A5, "R4");
    cfg(1'b0, 1'b0, 1'b1, 10'd100, "R8");
    wrt(16'h3B4, 8'h07, VGA, 10'd0, "R6");
    rd(16'h3B5, VGA, 10'd0, "R8");
    // color emulation
    cfg(1'b0, 1'b1, 1'b1, 10'd100, "R7");
    wrt(16'h3D4, 8'h0F, COLR, 10'h21F, "R5");
    rd(16'h3D5, COLR, 10'h2DF, "R9");
    rd(16'h3D8, COLR, 10'h23F, "R5");
    rd(16'h3D9, COLR, 10'h25F, "R5");
    rd(16'h3DD, COLR, 10'h29F, "R5");
    rd(16'h3DE, COLR, 10'h01F, "R5");
    rd(16'h3DB, NONE, 10'd0, "R7");
    wrt(16'h3DF, 8'h00, COLR, 10'h01F, "R5");
    rd(16'h3DC, NONE, 10'd0, "R9");
    wrt(16'h3DA, 8'h00, COLR, 10'h01F, "R5");
    rd(16'h3B5, VGA, 10'd0, "R6");
    rd(16'h3B8, NONE, 10'd0, "R6");
    // status synthesis
    cfg(1'b1, 1'b1, 1'b1, 10'd5, "R7");
    st(16'h3BA, 8'h09, "R10");
    idle(10);
    st(16'h3DA, 8'h09, "R10");
    cfg(1'b1, 1'b1, 1'b1, 10'd100, "R7");
    idle(10);
    st(16'h3DA, 8'h00, "R11");
    idle(40);
    st(16'h3BA, 8'h01, "R11");
    st(16'h3BA, 8'h00, "R11");
    cfg(1'b1, 1'b1, 1'b1, 10'd19, "R7");
    st(16'h3DA, 8'h09, "R10");
    cfg(1'b1, 1'b1, 1'b1, 10'd20, "R7");
    st(16'h3BA, 8'h00, "R10");
    idle(3);
    wait (q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule